// File: doc/BRIEF.md
# Three-Level Address Translation Walker

This block turns a 32-bit logical address into a physical address. It reads a three-level tree of 32-bit descriptors held in memory. A request carries the address, a supervisor flag and a write flag. The walker then reads the tree through a single 32-bit memory port. The first read is a root-table entry, the second a pointer-table entry and the third a page descriptor. If the page descriptor is indirect, one more read follows. Along the way the walker writes back any descriptor whose used flag is clear. After a successful write access it also sets the modified flag in the final page descriptor.

A control word selects 4 KiB or 8 KiB pages and can switch translation off. With translation off, the address is returned unchanged and memory is not touched. The two root pointers come in as register inputs, one for user accesses and one for supervisor accesses. Each result is reported as a physical address, a fault flag and a packed status word.

The walker is a single state machine with these states:
- `ST_IDLE`: waits for a request. A request with translation on goes to `ST_RD_ROOT`. A request with translation off goes to `ST_DONE`.
- `ST_RD_ROOT`: reads the root entry. It moves to `ST_WB_ROOT` when the entry's used flag is clear, otherwise to `ST_RD_PTR`.
- `ST_WB_ROOT`: writes the root entry back with its used flag set, then moves to `ST_RD_PTR`.
- `ST_RD_PTR`: reads the pointer entry. It moves to `ST_WB_PTR` when the entry's used flag is clear, otherwise to `ST_RD_PAGE`.
- `ST_WB_PTR`: writes the pointer entry back with its used flag set, then moves to `ST_RD_PAGE`.
- `ST_RD_PAGE`: reads the page descriptor. An indirect descriptor leads to `ST_RD_IND`.
- `ST_RD_IND`: reads the descriptor that an indirect descriptor points to.
- `ST_WB_PAGE`: writes the final page descriptor back when its flags changed, then moves to `ST_DONE`.
- `ST_DONE`: raises `done` for one cycle, then returns to `ST_IDLE`.

An invalid descriptor, a protection fault or a memory error sends the walk to `ST_DONE` at once.

Top module: `xlat_walker`

## Requirements
- R1: The root entry is read at `{root[31:9], va[31:25], 2'b00}`. The pointer entry is read at `{rootdesc[31:9], va[24:18], 2'b00}`. Each of these tables holds 128 word entries.
- R2: `ctrl[14]` selects the page size, with 0 meaning 4 KiB and 1 meaning 8 KiB.
  - For 4 KiB pages, the page descriptor is read at `{ptrdesc[31:8], va[17:12], 2'b00}` and `phys_addr = {pagedesc[31:12], va[11:0]}`.
  - For 8 KiB pages, the page descriptor is read at `{ptrdesc[31:7], va[17:13], 2'b00}` and `phys_addr = {pagedesc[31:13], va[12:0]}`.
- R3: When `ctrl[15]` is 0, `done` rises in the cycle after the request is accepted. In that case `phys_addr` equals the request address, no memory access is made, `fault` is 0 and `status` is `{va[31:12], 11'b0, 1'b1}`.
- R4: A request with `req_super` set uses `super_root`. A request with `req_super` clear uses `user_root`.
- R5: A root or pointer entry whose bit 1 is 0 (type 00 or 01) is invalid. It ends the walk with `fault` set and status bit 11 clear.
- R6: The page descriptor type is bits 1:0.
  - Type 00 is a fault.
  - Types 01 and 11 are resident.
  - Type 10 is indirect: the walker reads the descriptor at `{desc[31:2], 2'b00}` next. A target of type 00 or 10 is a fault.
- R7: Write protection is the OR of bit 2 of the root entry, the pointer entry and the final page descriptor.
  - A write to a protected page faults.
  - An access with `req_super` clear to a page whose bit 7 is set faults.
  - In both cases bit 4 is not set in memory.
- R8: Any root entry, pointer entry or final page descriptor read with bit 3 (used) clear is written back to the same address with bit 3 set. Invalid descriptors and indirect descriptors are never written.
- R9: A write access that succeeds leaves bit 4 (modified) set in the final page descriptor in memory before `done`. Status bit 4 then reads 1.
- R10: When `mem_err` is set with `mem_ack`, the walk ends. `fault` is set, status bit 11 is set and status bit 0 is clear.
- R11: The status word is `{pagedesc[31:12], buserr, pagedesc[10:4], 1'b0, wp, 1'b0, resident}`. Bits 6:5 give the cache mode: 00 write-through, 01 copy-back, 10 serialized non-cacheable, 11 non-cacheable. With 8 KiB pages, status bit 12 is undefined.
- R12: A request is accepted only in `ST_IDLE`. Requests raised while `busy` or `done` is high are ignored. `done` is a one-cycle pulse. `mem_req` is only high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Starts a walk when the walker is idle |
| req_addr | input | 32 | Logical address |
| req_super | input | 1 | Supervisor access |
| req_write | input | 1 | Write access |
| ctrl | input | 16 | Bit 15 enables translation; bit 14 selects 8 KiB pages |
| user_root | input | 32 | Root table base for user accesses |
| super_root | input | 32 | Root table base for supervisor accesses |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse when a result is ready |
| fault | output | 1 | The last walk faulted |
| phys_addr | output | 32 | Translated address |
| status | output | 32 | Packed result word |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | The access is a write |
| mem_addr | output | 32 | Word-aligned descriptor address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed; valid with `mem_ack` |

## Verification
The properties assume the following about the memory port:
- It answers every request eventually.
- `mem_rdata` and `mem_err` are meaningful only in a cycle where `mem_ack` is high.
- The request inputs matter only in the cycle where the walker is idle.

The bench memory acknowledges in the same cycle as the request, so `mem_ack` is exactly `mem_req`. It raises `mem_err` only for addresses above 4 KiB. Every descriptor tree the bench builds lies below that limit, except in the one case that deliberately points into the error region.

// File: rtl/xlat_walker_pkg.sv
package xlat_walker_pkg;

    localparam int VA_W       = 32;
    localparam int ROOT_IDX_W = 7;
    localparam int PTR_IDX_W  = 7;
    localparam int DESC_LOG   = 2;
    localparam int SMALL_OFF  = 12;
    localparam int BIG_OFF    = 13;

    localparam int CTRL_EN    = 15;
    localparam int CTRL_PGSZ  = 14;

    localparam int BIT_WP     = 2;
    localparam int BIT_USED   = 3;
    localparam int BIT_MOD    = 4;
    localparam int BIT_SUP    = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_ROOT,
        ST_WB_ROOT,
        ST_RD_PTR,
        ST_WB_PTR,
        ST_RD_PAGE,
        ST_RD_IND,
        ST_WB_PAGE,
        ST_DONE
    } walk_state_e;

endpackage

// File: rtl/xw_index.sv
module xw_index
    import xlat_walker_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic [VA_W-1:0] va_res,
    input  logic [VA_W-1:0] root,
    input  logic [VA_W-1:0] d_root,
    input  logic [VA_W-1:0] d_ptr,
    input  logic [VA_W-1:0] page,
    input  logic            big,
    input  logic            bypass,
    output logic [VA_W-1:0] root_slot,
    output logic [VA_W-1:0] ptr_slot,
    output logic [VA_W-1:0] page_slot,
    output logic [VA_W-1:0] phys
);
    localparam int RI_LO       = VA_W - ROOT_IDX_W;
    localparam int PI_LO       = RI_LO - PTR_IDX_W;
    localparam int ROOT_ALIGN  = ROOT_IDX_W + DESC_LOG;
    localparam int PTR_ALIGN   = PTR_IDX_W + DESC_LOG;
    localparam int SMALL_ALIGN = (PI_LO - SMALL_OFF) + DESC_LOG;
    localparam int BIG_ALIGN   = (PI_LO - BIG_OFF) + DESC_LOG;

    logic [DESC_LOG-1:0] word_pad;
    assign word_pad = '0;

    assign root_slot = {root[VA_W-1:ROOT_ALIGN], va[VA_W-1:RI_LO], word_pad};
    assign ptr_slot  = {d_root[VA_W-1:PTR_ALIGN], va[RI_LO-1:PI_LO], word_pad};

    always_comb begin
        if (big) begin
            page_slot = {d_ptr[VA_W-1:BIG_ALIGN], va[PI_LO-1:BIG_OFF], word_pad};
        end else begin
            page_slot = {d_ptr[VA_W-1:SMALL_ALIGN], va[PI_LO-1:SMALL_OFF], word_pad};
        end
    end

    always_comb begin
        if (bypass) begin
            phys = va_res;
        end else if (big) begin
            phys = {page[VA_W-1:BIG_OFF], va_res[BIG_OFF-1:0]};
        end else begin
            phys = {page[VA_W-1:SMALL_OFF], va_res[SMALL_OFF-1:0]};
        end
    end

    logic low_unused;
    assign low_unused = ^{root[ROOT_ALIGN-1:0], d_root[PTR_ALIGN-1:0],
                          d_ptr[BIG_ALIGN-1:0], page[SMALL_OFF-1:0]};

endmodule

// File: rtl/xw_decode.sv
module xw_decode (
    input  logic [1:0] dtype,
    output logic       upper_ok,
    output logic       page_inv,
    output logic       page_ind,
    output logic       page_res
);
    assign upper_ok = dtype[1];
    assign page_inv = (dtype == 2'b00);
    assign page_ind = (dtype == 2'b10);
    assign page_res = dtype[0];
endmodule

// File: rtl/xw_status.sv
module xw_status
    import xlat_walker_pkg::*;
(
    input  logic [VA_W-1:0] page,
    input  logic            wp,
    input  logic            berr,
    input  logic            ok,
    output logic [VA_W-1:0] status
);
    assign status = {page[VA_W-1:SMALL_OFF], berr, page[10:4], 1'b0, wp, 1'b0, ok};

    logic page_unused;
    assign page_unused = ^{page[11], page[3:0]};
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_walker_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_addr,
    input  logic            req_super,
    input  logic            req_write,
    input  logic [15:0]     ctrl,
    input  logic [VA_W-1:0] user_root,
    input  logic [VA_W-1:0] super_root,
    output logic            busy,
    output logic            done,
    output logic            fault,
    output logic [VA_W-1:0] phys_addr,
    output logic [VA_W-1:0] status,
    output logic            mem_req,
    output logic            mem_we,
    output logic [VA_W-1:0] mem_addr,
    output logic [VA_W-1:0] mem_wdata,
    input  logic [VA_W-1:0] mem_rdata,
    input  logic            mem_ack,
    input  logic            mem_err
);
    walk_state_e st_q, st_n;

    logic [VA_W-1:0] va_q, va_n, root_q, root_n, droot_q, droot_n, dptr_q, dptr_n;
    logic [VA_W-1:0] slot_q, slot_n, wdata_q, wdata_n, page_q, page_n;
    logic sup_q, sup_n, wr_q, wr_n, big_q, big_n, wp_q, wp_n;
    logic fault_q, fault_n, berr_q, berr_n, ok_q, ok_n, byp_q, byp_n;

    logic [VA_W-1:0] sel_root, va_in, root_in, droot_in, dptr_in;
    logic [VA_W-1:0] root_slot, ptr_slot, page_slot;
    logic upper_ok, page_inv, page_ind, page_res;
    logic in_mem, take_final, fin_wp, fin_prot;
    logic [VA_W-1:0] fin_desc;

    logic ctrl_unused;
    assign ctrl_unused = ^ctrl[13:0];

    assign sel_root = req_super ? super_root : user_root;
    assign va_in    = (st_q == ST_IDLE)    ? req_addr  : va_q;
    assign root_in  = (st_q == ST_IDLE)    ? sel_root  : root_q;
    assign droot_in = (st_q == ST_RD_ROOT) ? mem_rdata : droot_q;
    assign dptr_in  = (st_q == ST_RD_PTR)  ? mem_rdata : dptr_q;

    xw_index u_index (
        .va       (va_in),
        .va_res   (va_q),
        .root     (root_in),
        .d_root   (droot_in),
        .d_ptr    (dptr_in),
        .page     (page_q),
        .big      (big_q),
        .bypass   (byp_q),
        .root_slot(root_slot),
        .ptr_slot (ptr_slot),
        .page_slot(page_slot),
        .phys     (phys_addr)
    );

    xw_decode u_decode (
        .dtype   (mem_rdata[1:0]),
        .upper_ok(upper_ok),
        .page_inv(page_inv),
        .page_ind(page_ind),
        .page_res(page_res)
    );

    xw_status u_status (
        .page  (page_q),
        .wp    (wp_q),
        .berr  (berr_q),
        .ok    (ok_q),
        .status(status)
    );

    assign in_mem = (st_q != ST_IDLE) && (st_q != ST_DONE);

    // Final page descriptor handling: protection and flag updates
    always_comb begin
        fin_wp   = wp_q | mem_rdata[BIT_WP];
        fin_prot = (wr_q & fin_wp) | (~sup_q & mem_rdata[BIT_SUP]);
        fin_desc = mem_rdata;
        fin_desc[BIT_USED] = 1'b1;
        if (wr_q && !fin_prot) begin
            fin_desc[BIT_MOD] = 1'b1;
        end
    end

    // Next-state and datapath
    always_comb begin
        st_n = st_q;  va_n = va_q;  sup_n = sup_q;  wr_n = wr_q;  big_n = big_q;
        root_n = root_q;  droot_n = droot_q;  dptr_n = dptr_q;  slot_n = slot_q;
        wdata_n = wdata_q;  page_n = page_q;  wp_n = wp_q;  fault_n = fault_q;
        berr_n = berr_q;  ok_n = ok_q;  byp_n = byp_q;
        take_final = 1'b0;

        if (in_mem && mem_ack && mem_err) begin
            berr_n  = 1'b1;
            fault_n = 1'b1;
            ok_n    = 1'b0;
            st_n    = ST_DONE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_n = req_addr;  sup_n = req_super;  wr_n = req_write;
                        big_n = ctrl[CTRL_PGSZ];  root_n = sel_root;
                        droot_n = '0;  dptr_n = '0;  page_n = '0;
                        wp_n = 1'b0;  fault_n = 1'b0;  berr_n = 1'b0;  ok_n = 1'b0;
                        byp_n = ~ctrl[CTRL_EN];
                        if (!ctrl[CTRL_EN]) begin
                            page_n = {req_addr[VA_W-1:SMALL_OFF], {SMALL_OFF{1'b0}}};
                            ok_n   = 1'b1;
                            st_n   = ST_DONE;
                        end else begin
                            slot_n = root_slot;
                            st_n   = ST_RD_ROOT;
                        end
                    end
                end
                ST_RD_ROOT: begin
                    if (mem_ack) begin
                        if (!upper_ok) begin
                            fault_n = 1'b1;
                            st_n    = ST_DONE;
                        end else begin
                            droot_n = mem_rdata;
                            wp_n    = wp_q | mem_rdata[BIT_WP];
                            if (!mem_rdata[BIT_USED]) begin
                                wdata_n = mem_rdata | (VA_W'(1) << BIT_USED);
                                st_n    = ST_WB_ROOT;
                            end else begin
                                slot_n = ptr_slot;
                                st_n   = ST_RD_PTR;
                            end
                        end
                    end
                end
                ST_WB_ROOT: begin
                    if (mem_ack) begin
                        slot_n = ptr_slot;
                        st_n   = ST_RD_PTR;
                    end
                end
                ST_RD_PTR: begin
                    if (mem_ack) begin
                        if (!upper_ok) begin
                            fault_n = 1'b1;
                            st_n    = ST_DONE;
                        end else begin
                            dptr_n = mem_rdata;
                            wp_n   = wp_q | mem_rdata[BIT_WP];
                            if (!mem_rdata[BIT_USED]) begin
                                wdata_n = mem_rdata | (VA_W'(1) << BIT_USED);
                                st_n    = ST_WB_PTR;
                            end else begin
                                slot_n = page_slot;
                                st_n   = ST_RD_PAGE;
                            end
                        end
                    end
                end
                ST_WB_PTR: begin
                    if (mem_ack) begin
                        slot_n = page_slot;
                        st_n   = ST_RD_PAGE;
                    end
                end
                ST_RD_PAGE: begin
                    if (mem_ack) begin
                        if (page_inv) begin
                            fault_n = 1'b1;
                            st_n    = ST_DONE;
                        end else if (page_ind) begin
                            slot_n = {mem_rdata[VA_W-1:DESC_LOG], {DESC_LOG{1'b0}}};
                            st_n   = ST_RD_IND;
                        end else begin
                            take_final = 1'b1;
                        end
                    end
                end
                ST_RD_IND: begin
                    if (mem_ack) begin
                        if (!page_res) begin
                            fault_n = 1'b1;
                            st_n    = ST_DONE;
                        end else begin
                            take_final = 1'b1;
                        end
                    end
                end
                ST_WB_PAGE: begin
                    if (mem_ack) begin
                        st_n = ST_DONE;
                    end
                end
                ST_DONE: st_n = ST_IDLE;
                default: st_n = ST_IDLE;
            endcase

            if (take_final) begin
                page_n  = fin_desc;
                wp_n    = fin_wp;
                fault_n = fin_prot;
                ok_n    = ~fin_prot;
                if (fin_desc != mem_rdata) begin
                    wdata_n = fin_desc;
                    st_n    = ST_WB_PAGE;
                end else begin
                    st_n = ST_DONE;
                end
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            va_q <= '0;  root_q <= '0;  droot_q <= '0;  dptr_q <= '0;
            slot_q <= '0;  wdata_q <= '0;  page_q <= '0;
            sup_q <= 1'b0;  wr_q <= 1'b0;  big_q <= 1'b0;  wp_q <= 1'b0;
            fault_q <= 1'b0;  berr_q <= 1'b0;  ok_q <= 1'b0;  byp_q <= 1'b0;
        end else begin
            st_q <= st_n;
            va_q <= va_n;  root_q <= root_n;  droot_q <= droot_n;  dptr_q <= dptr_n;
            slot_q <= slot_n;  wdata_q <= wdata_n;  page_q <= page_n;
            sup_q <= sup_n;  wr_q <= wr_n;  big_q <= big_n;  wp_q <= wp_n;
            fault_q <= fault_n;  berr_q <= berr_n;  ok_q <= ok_n;  byp_q <= byp_n;
        end
    end

    // Outputs
    always_comb begin
        busy      = in_mem;
        done      = (st_q == ST_DONE);
        fault     = fault_q;
        mem_req   = in_mem;
        mem_we    = (st_q == ST_WB_ROOT) || (st_q == ST_WB_PTR) || (st_q == ST_WB_PAGE);
        mem_addr  = slot_q;
        mem_wdata = wdata_q;
    end

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        req_write,
    input logic [15:0] ctrl,
    input logic        busy,
    input logic        done,
    input logic        fault,
    input logic [31:0] phys_addr,
    input logic [31:0] status,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack
);
    logic wr_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_seen <= 1'b0;
        end else if (req_valid && !busy && !done) begin
            wr_seen <= req_write;
        end
    end

    a_r3_bypass_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !done && !ctrl[15]) |=> (done && phys_addr == $past(req_addr)));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_mem_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    a_r12_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    a_r8_writeback_used: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[3]);

    a_r10_berr_is_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status[11]) |-> fault);

    a_r11_resident_xor_fault: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault != status[0]));

    a_r7_write_ok_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && wr_seen) |-> !status[2]);

endmodule

bind xlat_walker xlat_walker_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .req_write(req_write),
    .ctrl     (ctrl),
    .busy     (busy),
    .done     (done),
    .fault    (fault),
    .phys_addr(phys_addr),
    .status   (status),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack)
);

// File: tb/xlat_walker_bench.sv
`timescale 1ns/1ps
module xlat_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_super = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] ctrl = '0;
    logic [31:0] user_root = 32'h0000_0000;
    logic [31:0] super_root = 32'h0000_0200;
    logic        busy, done, fault, mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] phys_addr, status, mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem  [0:1023];
    logic [31:0] emem [0:1023];
    logic        tb_clr = 1'b0, tb_we = 1'b0;
    logic [9:0]  tb_waddr = '0;
    logic [31:0] tb_wdata = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    xlat_walker u_xlat_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_super(req_super), .req_write(req_write), .ctrl(ctrl),
        .user_root(user_root), .super_root(super_root), .busy(busy), .done(done),
        .fault(fault), .phys_addr(phys_addr), .status(status), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err)
    );

    // Zero-wait memory; addresses at or above 4 KiB return an error
    always_comb begin
        mem_ack   = mem_req;
        mem_err   = mem_req && (mem_addr[31:12] != 20'h0);
        mem_rdata = mem[mem_addr[11:2]];
    end

    always @(posedge clk) begin
        if (tb_clr) begin
            for (int i = 0; i < 1024; i++) mem[i] <= '0;
        end else if (tb_we) begin
            mem[tb_waddr] <= tb_wdata;
        end else if (mem_req && mem_we && !mem_err) begin
            mem[mem_addr[11:2]] <= mem_wdata;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
        summary();
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        @(negedge clk); tb_clr = 1'b1;
        @(negedge clk); tb_clr = 1'b0;
        for (int i = 0; i < 1024; i++) emem[i] = '0;
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); tb_we = 1'b1; tb_waddr = a[11:2]; tb_wdata = d;
        @(negedge clk); tb_we = 1'b0;
        emem[a[11:2]] = d;
    endtask

    int          w_cyc, w_req;
    logic        w_fault;
    logic [31:0] w_phys, w_stat;

    task automatic walk(input logic [31:0] va, input bit sup, input bit wr, input logic [15:0] c);
        @(negedge clk);
        req_valid = 1'b1; req_addr = va; req_super = sup; req_write = wr; ctrl = c;
        @(negedge clk);
        req_valid = 1'b0;
        w_cyc = 1; w_req = 0;
        while (!done && w_cyc < 100) begin
            if (mem_req) w_req++;
            @(negedge clk);
            w_cyc++;
        end
        w_fault = fault; w_phys = phys_addr; w_stat = status;
    endtask

    // Reference walk over emem, following the requirements
    task automatic model(input logic [31:0] va, input bit sup, input bit wr, input bit big,
                         output bit f, output logic [31:0] ph, output bit wp, output logic [31:0] pd);
        logic [31:0] a, d, r;
        bit prot;
        f = 1'b0; ph = '0; wp = 1'b0; pd = '0;
        r = sup ? super_root : user_root;
        a = {r[31:9], va[31:25], 2'b00};
        d = emem[a[11:2]];
        if (!d[1]) begin f = 1'b1; return; end
        wp = d[2];
        if (!d[3]) emem[a[11:2]] = d | 32'h8;
        a = {d[31:9], va[24:18], 2'b00};
        d = emem[a[11:2]];
        if (!d[1]) begin f = 1'b1; return; end
        wp = wp | d[2];
        if (!d[3]) emem[a[11:2]] = d | 32'h8;
        a = big ? {d[31:7], va[17:13], 2'b00} : {d[31:8], va[17:12], 2'b00};
        d = emem[a[11:2]];
        if (d[1:0] == 2'b00) begin f = 1'b1; return; end
        if (d[1:0] == 2'b10) begin
            a = {d[31:2], 2'b00};
            d = emem[a[11:2]];
            if (!d[0]) begin f = 1'b1; return; end
        end
        wp   = wp | d[2];
        prot = (wr && wp) || (!sup && d[7]);
        pd   = d | 32'h8 | ((wr && !prot) ? 32'h10 : 32'h0);
        emem[a[11:2]] = pd;
        f  = prot;
        ph = big ? {pd[31:13], va[12:0]} : {pd[31:12], va[11:0]};
    endtask

    task automatic check_image(input string tag);
        int bad = 0;
        logic [31:0] first_a = '0, first_e = '0;
        for (int i = 0; i < 1024; i++) begin
            if (mem[i] !== emem[i]) begin
                if (bad == 0) begin first_a = mem[i]; first_e = emem[i]; end
                bad++;
            end
        end
        chk(bad == 0, tag, first_a, first_e);
    endtask

    initial begin
        int k = 0;
        int dn;
        logic [31:0] va, tgt, pslot, exp_st, msk, e_ph, e_pd;
        bit e_f, e_wp;
        logic [6:0] ri, pi;
        logic [19:0] pa;

        repeat (3) @(negedge clk);
        // R12: reset state
        chk(!busy && !done && !mem_req, "R12 reset idle", {29'b0, busy, done, mem_req}, 32'h0);
        rst_n = 1'b1;
        clear_mem();

        // R3: translation off
        walk(32'hDEAD_B123, 1'b0, 1'b1, 16'h4000);
        chk(w_cyc == 1, "R3 bypass latency", w_cyc, 1);
        chk(w_phys == 32'hDEAD_B123, "R3 bypass phys", w_phys, 32'hDEAD_B123);
        chk(w_req == 0 && !w_fault, "R3 bypass no memory", w_req, 0);
        chk(w_stat == 32'hDEAD_B001, "R3 bypass status", w_stat, 32'hDEAD_B001);

        // Sweep over page size, privilege, direction, page kind and flags
        for (int big = 0; big < 2; big++)
        for (int sup = 0; sup < 2; sup++)
        for (int wr = 0; wr < 2; wr++)
        for (int kind = 0; kind < 6; kind++)
        for (int sb = 0; sb < 2; sb++)
        for (int wpu = 0; wpu < 2; wpu++)
        for (int pre = 0; pre < 2; pre++) begin
            k++;
            ri = 7'(k * 5 + 1);
            pi = 7'(k * 3 + 2);
            va = big ? {ri, pi, 5'(k), 13'(k * 97 + 5)} : {ri, pi, 6'(k * 7), 12'(k * 53 + 3)};
            clear_mem();
            // R4: only the selected root table holds a valid entry
            poke((sup ? 32'h200 : 32'h0) + 32'(ri) * 4,
                 32'h400 | (pre ? 32'h8 : 32'h0) | (k[0] ? 32'h3 : 32'h2));
            poke(32'h400 + 32'(pi) * 4,
                 32'h600 | 32'(wpu) << 2 | 32'(pre) << 3 | 32'h3);
            pslot = big ? 32'h600 + 32'(va[17:13]) * 4 : 32'h600 + 32'(va[17:12]) * 4;
            pa  = {12'(k * 37 + 11), 8'hA5};
            tgt = {pa, 12'h0} | (k[1] ? 32'h400 : 32'h0) | 32'(sb) << 7 |
                  32'(k % 4) << 5 | (pre ? 32'h8 : 32'h0) | ((kind == 1) ? 32'h3 : 32'h1);
            unique case (kind)
                0, 1: poke(pslot, tgt);
                2:    poke(pslot, tgt & ~32'h3);
                3:    begin poke(pslot, 32'h902); poke(32'h900, tgt); end
                4:    begin poke(pslot, 32'h902); poke(32'h900, 32'hA02); end
                default: begin poke(pslot, 32'h906); poke(32'h904, tgt & ~32'h3); end
            endcase
            model(va, sup[0], wr[0], big[0], e_f, e_ph, e_wp, e_pd);
            walk(va, sup[0], wr[0], {1'b1, big[0], 14'h0});
            chk(w_fault == e_f, (kind >= 2) ? "R6 indirect/invalid fault" : "R4 R7 fault",
                {31'b0, w_fault}, {31'b0, e_f});
            if (!e_f) begin
                chk(w_phys == e_ph, "R1 R2 phys", w_phys, e_ph);
                exp_st = {e_pd[31:12], 1'b0, e_pd[10:4], 1'b0, e_wp, 1'b0, 1'b1};
                msk = big ? 32'hFFFF_EFFF : 32'hFFFF_FFFF;
                chk((w_stat & msk) == (exp_st & msk), "R9 R11 status", w_stat, exp_st);
            end else begin
                chk(w_stat[0] == 1'b0 && w_stat[11] == 1'b0, "R7 fault status", w_stat, 32'h0);
            end
            check_image("R8 R9 memory image");
        end

        // R10: pointer table address lies in the error region
        clear_mem();
        poke(32'h0 + 32'd3 * 4, 32'h0001_040A);
        walk({7'd3, 7'd1, 18'h0}, 1'b0, 1'b0, 16'h8000);
        chk(w_fault && w_stat[11] && !w_stat[0], "R10 bus error", w_stat, 32'h800);

        // R5: invalid root entry (type 01) faults and is not rewritten
        clear_mem();
        poke(32'h0 + 32'd4 * 4, 32'h0000_0401);
        walk({7'd4, 7'd2, 18'h0}, 1'b0, 1'b0, 16'h8000);
        chk(w_fault && !w_stat[11], "R5 root invalid", w_stat, 32'h0);
        check_image("R5 R8 invalid untouched");

        // R5: invalid pointer entry (type 00), also R12 ignore while busy
        clear_mem();
        poke(32'h200 + 32'd6 * 4, 32'h0000_040A);
        poke(32'h400 + 32'd9 * 4, 32'h0000_0608);
        @(negedge clk);
        req_valid = 1'b1; req_addr = {7'd6, 7'd9, 18'h0}; req_super = 1'b1; req_write = 1'b0;
        ctrl = 16'h8000;
        @(negedge clk);
        req_addr = 32'h1234_5678; ctrl = 16'h0000;
        dn = 0;
        for (int c = 0; c < 12; c++) begin
            if (done) dn++;
            @(negedge clk);
            req_valid = 1'b0;
        end
        chk(dn == 1, "R12 one done per request", dn, 1);
        chk(fault && phys_addr != 32'h1234_5678, "R5 R12 pointer invalid result", phys_addr, 32'h0);

        summary();
    end
endmodule